// File: doc/BRIEF.md
# Vector Load Split Buffer

The block holds one decoded vector load micro-op and turns it into a series of scalar memory requests for a scalar load pipeline. Each request goes out on a valid/ready channel, one per handshake. A unit-stride micro-op becomes one or two accesses to 16-byte aligned blocks. The count depends on whether the bytes it touches cross a 16-byte boundary. Strided and indexed micro-ops are issued one element at a time. Their address is formed from the base plus either the element number times the stride or that element's index offset.

A split counter walks the held record. Elements whose mask bit is clear are passed over without using a handshake, but they still move the counter on. When the counter reaches the number of pieces the record needs, the entry is released. A redirect tagged with an age older than the held record discards the record at once. Translation, caching and merging of returned data are handled elsewhere.

Top module: `vld_split_buf`

## Requirements
- R1: `in_ready` is high exactly while no record is held; a record is taken on a cycle with `in_valid` and `in_ready` both high, and `in_ready` is low on the following cycle.
- R2: A unit-stride record (`in_kind` = 0) whose bytes (`in_elem_cnt << in_esize`) stay within one 16-byte aligned block issues one request with size code 4, the base with its low four bits cleared as address, and piece index 0.
- R3: A unit-stride record whose bytes cross a 16-byte boundary issues two requests, both with size code 4. The first goes to the aligned block holding the base, with index 0. The second goes to that block plus 16, with index 1.
- R4: A strided record (`in_kind` = 1) issues element i at `base + i*stride`, taken modulo the address width. The size code equals `in_esize` (0 byte, 1 half, 2 word, 3 double), and the piece index is i.
- R5: An indexed record (`in_kind` = 2 or 3) issues element i at `base + in_offsets[i*VA_W +: VA_W]`, with the same size coding as R4.
- R6: In strided and indexed records, an element whose `in_mask` bit i is 0 produces no request, and later elements keep their own index and address. Unit-stride records ignore `in_mask`.
- R7: While `out_valid` is high and `out_ready` is low, the address, size, index and id outputs stay unchanged on the next cycle.
- R8: After the handshake (or skip) of the last needed piece, `in_ready` is high on the next cycle. A record with zero elements, or with every element masked off, is released without issuing anything.
- R9: With a record held, a redirect whose `redir_age` is smaller than the record's age (unsigned compare) forces `out_valid` low in that cycle, and `in_ready` is high on the next cycle.
- R10: A redirect whose age is equal to or larger than the held record's age leaves the record and its requests untouched.
- R11: Every request carries on `out_mbid` the merge-buffer id taken with the record.
- R12: During and right after reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decoded record offered |
| in_ready | output | 1 | Buffer is free to take a record |
| in_kind | input | 2 | 0 unit-stride, 1 strided, 2/3 indexed |
| in_base | input | VA_W | Base virtual address |
| in_stride | input | VA_W | Byte stride for strided loads |
| in_offsets | input | MAX_ELEM*VA_W | Per-element index offsets, element i at bits [i*VA_W +: VA_W] |
| in_mask | input | MAX_ELEM | Element enable bits |
| in_elem_cnt | input | CNT_W | Number of elements in the micro-op |
| in_esize | input | 2 | log2 of element bytes |
| in_age | input | AGE_W | Age tag of the owning instruction |
| in_mbid | input | MBID_W | Merge-buffer entry id |
| redir_valid | input | 1 | Redirect present |
| redir_age | input | AGE_W | Age tag of the redirecting instruction |
| out_valid | output | 1 | Request valid |
| out_ready | input | 1 | Load pipeline accepts request |
| out_addr | output | VA_W | Request virtual address |
| out_size | output | 3 | Access size code, 4 = 16-byte block |
| out_idx | output | EI_W | Element or piece index |
| out_mbid | output | MBID_W | Merge-buffer entry id |

## Verification
The checks assume two things about the upstream decoder. It never offers more than MAX_ELEM elements, and a unit-stride record never covers more than 16 bytes. Both are asserted as input constraints on `in_valid`. The assertions also assume that age tags do not wrap while a record is held, so a plain unsigned compare orders them. The stimulus keeps every record within these bounds and uses small, distinct age values. Each record is driven for one cycle only, while `in_ready` is high.

// File: rtl/vls_pkg.sv
// Shared encodings for the vector load split buffer.
// Assumes the block size for unit-stride accesses is 16 bytes.
package vls_pkg;
    typedef enum logic [1:0] {
        KIND_UNIT   = 2'd0,
        KIND_STRIDE = 2'd1,
        KIND_INDEX  = 2'd2,
        KIND_INDEX2 = 2'd3
    } vls_kind_e;

    localparam int BLK_LSB   = 4;
    localparam int BLK_BYTES = 1 << BLK_LSB;
    localparam logic [2:0] SZ_BLOCK = 3'd4;
endpackage

// File: rtl/vls_piece_cnt.sv
// Computes how many pieces a record needs when it is taken.
// Unit-stride: 0, 1 or 2 block accesses depending on boundary crossing.
// Others: one piece slot per element (masked ones are skipped later).
// Assumes a unit-stride record spans at most one block's worth of bytes.
module vls_piece_cnt
    import vls_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [1:0]         kind,
    input  logic [BLK_LSB-1:0] base_lo,
    input  logic [1:0]         esize,
    input  logic [CNT_W-1:0]   elem_cnt,
    output logic [CNT_W-1:0]   need
);
    localparam int BYTES_W = CNT_W + 3;

    logic [BYTES_W-1:0] span_bytes;
    logic [BYTES_W:0]   last_off;
    logic [CNT_W-1:0]   unit_need;

    // Byte span of a unit-stride record and the offset of its last byte.
    always_comb begin
        span_bytes = {3'b000, elem_cnt} << esize;
        last_off   = {{(BYTES_W + 1 - BLK_LSB){1'b0}}, base_lo} + {1'b0, span_bytes}
                     - (BYTES_W + 1)'(1);
        if (span_bytes == '0)
            unit_need = '0;
        else if (last_off >= (BYTES_W + 1)'(BLK_BYTES))
            unit_need = CNT_W'(2);
        else
            unit_need = CNT_W'(1);
    end

    // Select count by kind.
    always_comb begin
        need = (kind == KIND_UNIT) ? unit_need : elem_cnt;
    end
endmodule

// File: rtl/vls_addr_gen.sv
// Forms the address and size code of the piece at split index idx.
// Unit-stride: aligned block, plus one block for piece 1.
// Strided: base + idx*stride. Indexed: base + offset[idx].
// Assumes idx < MAX_ELEM whenever the result is used.
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int MAX_ELEM = 16,
    parameter int CNT_W    = 5,
    parameter int EI_W     = 4
) (
    input  logic [1:0]               kind,
    input  logic [VA_W-1:0]          base,
    input  logic [VA_W-1:0]          stride,
    input  logic [MAX_ELEM*VA_W-1:0] offs_flat,
    input  logic [1:0]               esize,
    input  logic [CNT_W-1:0]         idx,
    output logic [VA_W-1:0]          addr,
    output logic [2:0]               size
);
    logic [VA_W-1:0] offs [MAX_ELEM];
    logic [VA_W-1:0] blk_addr;
    logic [VA_W-1:0] unit_addr;
    logic [VA_W-1:0] scaled;
    logic [EI_W-1:0] eidx;

    for (genvar g = 0; g < MAX_ELEM; g++) begin : g_offs
        assign offs[g] = offs_flat[g*VA_W +: VA_W];
    end

    // Candidate addresses for each kind.
    always_comb begin
        eidx      = idx[EI_W-1:0];
        blk_addr  = {base[VA_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
        unit_addr = blk_addr + (idx[0] ? VA_W'(BLK_BYTES) : '0);
        scaled    = stride * VA_W'(idx);
    end

    // Kind select for address and size.
    always_comb begin
        unique case (kind)
            KIND_UNIT:   begin addr = unit_addr;           size = SZ_BLOCK;        end
            KIND_STRIDE: begin addr = base + scaled;       size = {1'b0, esize};   end
            default:     begin addr = base + offs[eidx];   size = {1'b0, esize};   end
        endcase
    end
endmodule

// File: rtl/vls_walk_ctl.sv
// Occupancy flag and split-index counter of the single entry.
// Flush has priority over everything; accept only arrives while free.
// The entry frees on the edge where the last piece advances, or
// one cycle after acceptance if no pieces are needed.
module vls_walk_ctl #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             flush,
    input  logic             advance,
    input  logic [CNT_W-1:0] need,
    output logic             busy,
    output logic [CNT_W-1:0] idx
);
    logic [CNT_W-1:0] idx_nx;

    // Next split index.
    always_comb begin
        idx_nx = idx + CNT_W'(1);
    end

    // Occupancy and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (flush) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx >= need) begin
                busy <= 1'b0;
                idx  <= '0;
            end else if (advance) begin
                if (idx_nx >= need) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx_nx;
                end
            end
        end
    end
endmodule

// File: rtl/vld_split_buf.sv
// Single-entry vector load split buffer.
// Takes one decoded record, issues its pieces to a scalar load pipeline
// one per handshake, skips masked-off elements and drops the record on
// a redirect from an older instruction. Age tags are assumed not to wrap
// while a record is held.
module vld_split_buf
    import vls_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int MAX_ELEM = 16,
    parameter int AGE_W    = 8,
    parameter int MBID_W   = 4,
    localparam int CNT_W   = $clog2(MAX_ELEM + 1),
    localparam int EI_W    = $clog2(MAX_ELEM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_kind,
    input  logic [VA_W-1:0]          in_base,
    input  logic [VA_W-1:0]          in_stride,
    input  logic [MAX_ELEM*VA_W-1:0] in_offsets,
    input  logic [MAX_ELEM-1:0]      in_mask,
    input  logic [CNT_W-1:0]         in_elem_cnt,
    input  logic [1:0]               in_esize,
    input  logic [AGE_W-1:0]         in_age,
    input  logic [MBID_W-1:0]        in_mbid,
    input  logic                     redir_valid,
    input  logic [AGE_W-1:0]         redir_age,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [VA_W-1:0]          out_addr,
    output logic [2:0]               out_size,
    output logic [EI_W-1:0]          out_idx,
    output logic [MBID_W-1:0]        out_mbid
);
    logic [1:0]               ent_kind;
    logic [VA_W-1:0]          ent_base;
    logic [VA_W-1:0]          ent_stride;
    logic [MAX_ELEM*VA_W-1:0] ent_offs;
    logic [MAX_ELEM-1:0]      ent_mask;
    logic [CNT_W-1:0]         ent_need;
    logic [1:0]               ent_esize;
    logic [AGE_W-1:0]         ent_age;
    logic [MBID_W-1:0]        ent_mbid;

    logic [CNT_W-1:0] need_in;
    logic [CNT_W-1:0] idx;
    logic             busy;
    logic             accept;
    logic             flush;
    logic             pending;
    logic             elem_on;
    logic             advance;

    vls_piece_cnt #(.CNT_W(CNT_W)) cnt_i (
        .kind     (in_kind),
        .base_lo  (in_base[BLK_LSB-1:0]),
        .esize    (in_esize),
        .elem_cnt (in_elem_cnt),
        .need     (need_in)
    );

    // Capture the record on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_kind   <= '0;
            ent_base   <= '0;
            ent_stride <= '0;
            ent_offs   <= '0;
            ent_mask   <= '0;
            ent_need   <= '0;
            ent_esize  <= '0;
            ent_age    <= '0;
            ent_mbid   <= '0;
        end else if (accept) begin
            ent_kind   <= in_kind;
            ent_base   <= in_base;
            ent_stride <= in_stride;
            ent_offs   <= in_offsets;
            ent_mask   <= in_mask;
            ent_need   <= need_in;
            ent_esize  <= in_esize;
            ent_age    <= in_age;
            ent_mbid   <= in_mbid;
        end
    end

    // Handshake, flush and skip decisions.
    always_comb begin
        in_ready  = !busy;
        accept    = in_valid && in_ready;
        flush     = busy && redir_valid && (ent_age > redir_age);
        pending   = busy && !flush && (idx < ent_need);
        elem_on   = (ent_kind == KIND_UNIT) || ent_mask[idx[EI_W-1:0]];
        out_valid = pending && elem_on;
        advance   = pending && (!elem_on || out_ready);
        out_idx   = idx[EI_W-1:0];
        out_mbid  = ent_mbid;
    end

    vls_walk_ctl #(.CNT_W(CNT_W)) walk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .flush   (flush),
        .advance (advance),
        .need    (ent_need),
        .busy    (busy),
        .idx     (idx)
    );

    vls_addr_gen #(
        .VA_W     (VA_W),
        .MAX_ELEM (MAX_ELEM),
        .CNT_W    (CNT_W),
        .EI_W     (EI_W)
    ) addr_i (
        .kind      (ent_kind),
        .base      (ent_base),
        .stride    (ent_stride),
        .offs_flat (ent_offs),
        .esize     (ent_esize),
        .idx       (idx),
        .addr      (out_addr),
        .size      (out_size)
    );
endmodule

// File: rtl/vld_split_buf_chk.sv
// Property checker for vld_split_buf, attached by bind.
// Tracks the age and id of the held record from the input handshake.
module vld_split_buf_chk
    import vls_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int MAX_ELEM = 16,
    parameter int AGE_W    = 8,
    parameter int MBID_W   = 4,
    localparam int CNT_W   = $clog2(MAX_ELEM + 1),
    localparam int EI_W    = $clog2(MAX_ELEM)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_kind,
    input logic [CNT_W-1:0]  in_elem_cnt,
    input logic [1:0]        in_esize,
    input logic [AGE_W-1:0]  in_age,
    input logic [MBID_W-1:0] in_mbid,
    input logic              redir_valid,
    input logic [AGE_W-1:0]  redir_age,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VA_W-1:0]   out_addr,
    input logic [2:0]        out_size,
    input logic [EI_W-1:0]   out_idx,
    input logic [MBID_W-1:0] out_mbid
);
    logic [AGE_W-1:0]  seen_age;
    logic [MBID_W-1:0] seen_mbid;
    logic [CNT_W+2:0]  in_bytes;
    logic              older_redir;

    // Remember tags of the record most recently taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_age  <= '0;
            seen_mbid <= '0;
        end else if (in_valid && in_ready) begin
            seen_age  <= in_age;
            seen_mbid <= in_mbid;
        end
    end

    // Derived helper terms.
    always_comb begin
        in_bytes    = {3'b000, in_elem_cnt} << in_esize;
        older_redir = redir_valid && !in_ready && (seen_age > redir_age);
    end

    p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    p_blk_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_size == SZ_BLOCK) |-> (out_addr[BLK_LSB-1:0] == '0));

    p_unit_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_kind == 2'd0) |-> (in_bytes <= (CNT_W + 3)'(BLK_BYTES)));

    p_size_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size <= SZ_BLOCK));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> !out_valid ||
            ($stable(out_addr) && $stable(out_size) && $stable(out_idx) && $stable(out_mbid)));

    p_elem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_elem_cnt <= CNT_W'(MAX_ELEM)));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        older_redir |-> !out_valid);

    p_flush_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        older_redir |=> in_ready);

    p_mbid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mbid == seen_mbid));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);
endmodule

bind vld_split_buf vld_split_buf_chk #(
    .VA_W     (VA_W),
    .MAX_ELEM (MAX_ELEM),
    .AGE_W    (AGE_W),
    .MBID_W   (MBID_W)
) chk_i (.*);

// File: tb/vld_split_buf_tb_top.sv
module vld_split_buf_tb_top;
    localparam int VA_W     = 32;
    localparam int MAX_ELEM = 16;
    localparam int AGE_W    = 8;
    localparam int MBID_W   = 4;
    localparam int CNT_W    = $clog2(MAX_ELEM + 1);
    localparam int EI_W     = $clog2(MAX_ELEM);

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] base;
        logic [31:0] stride;
        logic [1:0]  esz;
        logic [4:0]  cnt;
        logic [15:0] mask;
        logic [3:0]  mbid;
        logic        stall;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0000_1000, 32'h0, 2'd2, 5'd4,  16'hFFFF, 4'd1, 1'b0},
        '{2'd0, 32'h0000_2006, 32'h0, 2'd1, 5'd8,  16'hFFFF, 4'd2, 1'b1},
        '{2'd0, 32'h0000_300F, 32'h0, 2'd0, 5'd1,  16'h0000, 4'd3, 1'b0},
        '{2'd1, 32'h0000_4000, 32'h24, 2'd2, 5'd5, 16'h001F, 4'd4, 1'b1},
        '{2'd1, 32'h0000_5000, 32'h8, 2'd3, 5'd6,  16'h0029, 4'd5, 1'b0},
        '{2'd2, 32'h0000_6000, 32'h0, 2'd0, 5'd16, 16'hFFFF, 4'd6, 1'b1},
        '{2'd2, 32'h0000_7000, 32'h0, 2'd1, 5'd4,  16'h0005, 4'd7, 1'b0},
        '{2'd1, 32'h0000_8000, 32'hFFFF_FFF0, 2'd2, 5'd3, 16'h0007, 4'd8, 1'b0},
        '{2'd0, 32'h0000_900E, 32'h0, 2'd2, 5'd1,  16'hFFFF, 4'd9, 1'b0}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [1:0]               in_kind = '0;
    logic [VA_W-1:0]          in_base = '0;
    logic [VA_W-1:0]          in_stride = '0;
    logic [MAX_ELEM*VA_W-1:0] in_offsets = '0;
    logic [MAX_ELEM-1:0]      in_mask = '0;
    logic [CNT_W-1:0]         in_elem_cnt = '0;
    logic [1:0]               in_esize = '0;
    logic [AGE_W-1:0]         in_age = '0;
    logic [MBID_W-1:0]        in_mbid = '0;
    logic                     redir_valid = 1'b0;
    logic [AGE_W-1:0]         redir_age = '0;
    logic                     out_valid;
    logic                     out_ready = 1'b1;
    logic [VA_W-1:0]          out_addr;
    logic [2:0]               out_size;
    logic [EI_W-1:0]          out_idx;
    logic [MBID_W-1:0]        out_mbid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] exp_addr [MAX_ELEM];
    logic [2:0]  exp_size [MAX_ELEM];
    int          exp_idx  [MAX_ELEM];
    int          n_exp;

    always #4 clk = ~clk;

    vld_split_buf #(
        .VA_W(VA_W), .MAX_ELEM(MAX_ELEM), .AGE_W(AGE_W), .MBID_W(MBID_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_base(in_base), .in_stride(in_stride),
        .in_offsets(in_offsets), .in_mask(in_mask), .in_elem_cnt(in_elem_cnt),
        .in_esize(in_esize), .in_age(in_age), .in_mbid(in_mbid),
        .redir_valid(redir_valid), .redir_age(redir_age),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_size(out_size), .out_idx(out_idx), .out_mbid(out_mbid)
    );

    function automatic logic [31:0] off_of(int i);
        return 32'(i) * 32'h104 + 32'h3;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual %0d expected below 50000 cycles", cyc);
            summary();
            $finish;
        end
    end

    // Expected piece list derived from the requirements.
    task automatic build_exp(vec_t v);
        int bytes;
        logic [31:0] lo, hi;
        n_exp = 0;
        if (v.kind == 2'd0) begin
            bytes = int'(v.cnt) << v.esz;
            lo = v.base & 32'hFFFF_FFF0;
            hi = (v.base + 32'(bytes) - 32'd1) & 32'hFFFF_FFF0;
            if (bytes != 0) begin
                exp_addr[0] = lo; exp_size[0] = 3'd4; exp_idx[0] = 0; n_exp = 1;
                if (hi != lo) begin
                    exp_addr[1] = lo + 32'd16; exp_size[1] = 3'd4; exp_idx[1] = 1; n_exp = 2;
                end
            end
        end else begin
            for (int i = 0; i < int'(v.cnt); i++) begin
                if (v.mask[i]) begin
                    exp_addr[n_exp] = (v.kind == 2'd1) ? v.base + 32'(i) * v.stride
                                                        : v.base + off_of(i);
                    exp_size[n_exp] = {1'b0, v.esz};
                    exp_idx[n_exp]  = i;
                    n_exp++;
                end
            end
        end
    endtask

    // Offer one record for a single cycle (called at a negedge with in_ready high).
    task automatic load(vec_t v, logic [AGE_W-1:0] age);
        in_kind = v.kind; in_base = v.base; in_stride = v.stride;
        in_esize = v.esz; in_elem_cnt = v.cnt; in_mask = v.mask;
        in_mbid = v.mbid; in_age = age; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Drive a record and compare every issued piece against the expected list.
    task automatic run_vec(vec_t v, logic [AGE_W-1:0] age, string req);
        int got = 0;
        bit prev_stall = 1'b0;
        logic [31:0] hold_addr = '0;
        int hold_idx = 0;
        build_exp(v);
        load(v, age);
        for (int k = 0; k < 200; k++) begin
            out_ready = !(v.stall && (k % 3 == 1));
            #1;
            if (in_ready) break;
            if (out_valid) begin
                if (prev_stall) begin
                    chk(out_addr == hold_addr, "R7", "held address", out_addr, hold_addr);
                    chk(int'(out_idx) == hold_idx, "R7", "held index", 32'(out_idx), 32'(hold_idx));
                end
                if (out_ready) begin
                    if (got < n_exp) begin
                        chk(out_addr == exp_addr[got], req, "address", out_addr, exp_addr[got]);
                        chk(out_size == exp_size[got], req, "size code", 32'(out_size), 32'(exp_size[got]));
                        chk(int'(out_idx) == exp_idx[got], req, "piece index", 32'(out_idx), 32'(exp_idx[got]));
                        chk(out_mbid == v.mbid, "R11", "merge id", 32'(out_mbid), 32'(v.mbid));
                    end
                    got++;
                end
                prev_stall = !out_ready;
                hold_addr  = out_addr;
                hold_idx   = int'(out_idx);
            end else begin
                prev_stall = 1'b0;
            end
            @(negedge clk);
        end
        chk(got == n_exp, "R8", "piece count", 32'(got), 32'(n_exp));
        chk(in_ready == 1'b1, "R8", "entry released", 32'(in_ready), 32'd1);
        out_ready = 1'b1;
    endtask

    initial begin
        vec_t d;
        string tag;
        for (int i = 0; i < MAX_ELEM; i++) in_offsets[i*VA_W +: VA_W] = off_of(i);

        // R12: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R12", "in_ready in reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R12", "out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R12", "in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R12", "out_valid after reset", 32'(out_valid), 32'd0);
        @(negedge clk);

        // Table walk: R2, R3, R4, R5, R6 by kind.
        for (int n = 0; n < NVEC; n++) begin
            if (VECS[n].kind == 2'd0) tag = (n == 1 || n == 8) ? "R3" : "R2";
            else if (VECS[n].kind == 2'd1) tag = (VECS[n].mask != 16'h001F && VECS[n].mask != 16'h0007) ? "R6" : "R4";
            else tag = (VECS[n].mask == 16'h0005) ? "R6" : "R5";
            run_vec(VECS[n], 8'd0, tag);
        end

        // R8: zero-element record issues nothing and frees.
        d = '{2'd1, 32'h0000_A000, 32'h4, 2'd2, 5'd0, 16'hFFFF, 4'd10, 1'b0};
        run_vec(d, 8'd0, "R8");

        // R6: all elements masked off.
        d = '{2'd2, 32'h0000_B000, 32'h0, 2'd2, 5'd4, 16'h0000, 4'd11, 1'b0};
        run_vec(d, 8'd0, "R6");

        // R9: older redirect flushes, even with out_ready high.
        d = '{2'd1, 32'h0000_C000, 32'h4, 2'd2, 5'd4, 16'hFFFF, 4'd12, 1'b0};
        load(d, 8'd9);
        redir_valid = 1'b1; redir_age = 8'd4; out_ready = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R9", "out_valid on flush", 32'(out_valid), 32'd0);
        @(negedge clk);
        redir_valid = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9", "free after flush", 32'(in_ready), 32'd1);
        @(negedge clk);

        // R10: equal and younger redirects leave the record alone.
        d = '{2'd1, 32'h0000_D000, 32'h10, 2'd2, 5'd3, 16'h0007, 4'd13, 1'b0};
        load(d, 8'd5);
        out_ready = 1'b0;
        redir_valid = 1'b1; redir_age = 8'd5;
        #1;
        chk(out_valid == 1'b1, "R10", "equal age kept", 32'(out_valid), 32'd1);
        chk(out_addr == 32'h0000_D000, "R10", "address kept", out_addr, 32'h0000_D000);
        @(negedge clk);
        redir_age = 8'd7;
        #1;
        chk(out_valid == 1'b1, "R10", "younger redirect ignored", 32'(out_valid), 32'd1);
        chk(in_ready == 1'b0, "R1", "busy while held", 32'(in_ready), 32'd0);
        @(negedge clk);
        redir_valid = 1'b0;
        out_ready = 1'b1;
        for (int e = 0; e < 3; e++) begin
            #1;
            chk(out_addr == 32'h0000_D000 + 32'(e) * 32'h10, "R10", "element address after redirect",
                out_addr, 32'h0000_D000 + 32'(e) * 32'h10);
            @(negedge clk);
        end
        #1;
        chk(in_ready == 1'b1, "R8", "free after last piece", 32'(in_ready), 32'd1);

        summary();
        $finish;
    end
endmodule